// File: doc/BRIEF.md
# Reset Cause and Local Interrupt Control Registers

This block sits in a board-management logic device behind a small host port that selects a register by index and reads or writes it. It keeps a one-byte record of what caused the most recent reset. It also holds a one-byte control register that gates four outputs toward the CPU: an enumeration interrupt, an ejector-latch interrupt, an INIT request on soft reset and a non-maskable interrupt request.

Reset causes arrive as single-cycle pulses, one wire per cause, and are recorded one-hot. The enumeration input is active low and is latched on its falling edge. Every other input is active high. The ejector interrupt is a plain level that follows the latch while it is enabled.

Top module: `rst_irq_regs`

## Requirements
- R1: After rst_n is deasserted, index 0x04 reads 0x20 and index 0x05 reads 0x04 (only the INIT enable set), and irq7, irq11 and nmi_out are low.
- R2: Index 0x04 is read/write. Its bits from D7 to D0 are failed soft reset, management controller, power-on, software I/O write, front panel, rear module, backplane and watchdog. A write is visible on rd_data in the cycle after the write edge.
- R3: On any cycle where rst_evt is nonzero, index 0x04 is overwritten with rst_evt. Causes that arrive in the same cycle are merged by OR, and an event takes priority over a host write in the same cycle.
- R4: Index 0x05 holds the IRQ7 enable at D6, the IRQ11 enable at D4, the INIT enable at D2 and the NMI enable at D0. D7, D5, D3 and D1 read as zero and are not stored.
- R5: init_out is high in exactly those cycles where soft_rst is high and the INIT enable (D2) is set.
- R6: irq11 is high whenever latch_open is high and the IRQ11 enable (D4) is set. It follows latch_open in the same cycle.
- R7: A falling edge on enum_n, seen at a clock edge while the IRQ7 enable (D6) is set, raises irq7 from that edge onward. An edge seen while D6 is clear is not recorded.
- R8: A pending irq7 is cleared by a write to index 0x05 with D7 set, or by a write that clears D6. It stays clear while enum_n stays low.
- R9: nmi_out is high whenever nmi_req is high and the NMI enable (D0) is set.
- R10: Any index other than 0x04 and 0x05 reads 0x00, and writes to it change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| idx | input | 8 | Register index |
| wr_en | input | 1 | Write strobe for the selected index |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected index (combinational) |
| rst_evt | input | 8 | Reset cause pulses, one bit per cause in register order |
| soft_rst | input | 1 | Soft reset pulse |
| latch_open | input | 1 | Ejector latch open, active high |
| enum_n | input | 1 | Enumeration signal, active low |
| nmi_req | input | 1 | Raw NMI request |
| irq7 | output | 1 | Enumeration interrupt |
| irq11 | output | 1 | Ejector latch interrupt |
| init_out | output | 1 | CPU INIT request |
| nmi_out | output | 1 | Gated NMI |

## Verification
Read data, irq11, init_out and nmi_out are combinational. They are due in the same cycle as their stimulus, so the bench checks them a short delay after driving, before the next clock edge. Register writes, reset events and enumeration edges take effect at one clock edge. The bench drives each of these on a falling clock edge, lets exactly one rising edge pass, and then checks away from the edge. Each check is pushed into a queue and compared by a separate monitor at that moment.

// File: rtl/rst_irq_regs.sv
module rst_irq_regs #(
  parameter logic [7:0] CAUSE_IDX = 8'h04,
  parameter logic [7:0] CTRL_IDX  = 8'h05,
  parameter logic [7:0] CAUSE_DEF = 8'h20,
  parameter logic [7:0] CTRL_DEF  = 8'h04
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] idx,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rd_data,
  input  logic [7:0] rst_evt,
  input  logic       soft_rst,
  input  logic       latch_open,
  input  logic       enum_n,
  input  logic       nmi_req,
  output logic       irq7,
  output logic       irq11,
  output logic       init_out,
  output logic       nmi_out
);
  localparam logic [7:0] CTRL_MASK = 8'h55;

  logic [7:0] cause_q;
  logic [7:0] ctrl_q;
  logic       enum_q;
  logic       pend_q;

  wire wr_cause = wr_en && (idx == CAUSE_IDX);
  wire wr_ctrl  = wr_en && (idx == CTRL_IDX);
  wire en7      = ctrl_q[6];
  wire enum_fall = enum_q && !enum_n;
  wire clr7     = wr_ctrl && (wdata[7] || !wdata[6]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= CAUSE_DEF;
      ctrl_q  <= CTRL_DEF & CTRL_MASK;
      enum_q  <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      enum_q <= enum_n;
      if (rst_evt != 8'h00)
        cause_q <= rst_evt;
      else if (wr_cause)
        cause_q <= wdata;
      if (wr_ctrl)
        ctrl_q <= wdata & CTRL_MASK;
      if (enum_fall && en7)
        pend_q <= 1'b1;
      else if (clr7)
        pend_q <= 1'b0;
    end
  end

  always_comb begin
    case (idx)
      CAUSE_IDX: rd_data = cause_q;
      CTRL_IDX:  rd_data = ctrl_q;
      default:   rd_data = 8'h00;
    endcase
  end

  assign irq7     = pend_q;
  assign irq11    = ctrl_q[4] && latch_open;
  assign init_out = ctrl_q[2] && soft_rst;
  assign nmi_out  = ctrl_q[0] && nmi_req;
endmodule

module rst_irq_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] idx,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rd_data,
  input logic [7:0] rst_evt,
  input logic       soft_rst,
  input logic       latch_open,
  input logic       enum_n,
  input logic       nmi_req,
  input logic       irq7,
  input logic       irq11,
  input logic       init_out,
  input logic       nmi_out
);
  AST_EVT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt != 8'h00) |=> (idx != 8'h04 || rd_data == $past(rst_evt))); // R3
  AST_CTRL_ODD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == 8'h05) |-> ((rd_data & 8'hAA) == 8'h00)); // R4
  AST_INIT_NEEDS_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    init_out |-> soft_rst); // R5
  AST_IRQ11_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq11 |-> latch_open); // R6
  AST_IRQ7_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(enum_n) && idx == 8'h05 && !wr_en && rd_data[6]) |=> irq7); // R7
  AST_IRQ7_STRB_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 8'h05 && wdata[7] && enum_n) |=> !irq7); // R8
  AST_NMI_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_out |-> nmi_req); // R9
  AST_OTHER_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != 8'h04 && idx != 8'h05) |-> (rd_data == 8'h00)); // R10
endmodule

bind rst_irq_regs rst_irq_regs_chk u_chk (.*);

// File: tb/tb_rst_irq_regs.sv
module tb_rst_irq_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] idx = 8'h00, wdata = 8'h00, rst_evt = 8'h00;
  logic wr_en = 1'b0, soft_rst = 1'b0, latch_open = 1'b0, enum_n = 1'b1, nmi_req = 1'b0;
  logic [7:0] rd_data;
  logic irq7, irq11, init_out, nmi_out;

  always #10 clk = ~clk;

  rst_irq_regs dut (.*);

  typedef struct { int kind; logic [7:0] exp; string req; } item_t;
  item_t q[$];
  event chk_ev;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always begin
    @(chk_ev);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = rd_data;
        1: act = {7'b0, irq7};
        2: act = {7'b0, irq11};
        3: act = {7'b0, init_out};
        default: act = {7'b0, nmi_out};
      endcase
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_v(input int kind, input logic [7:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    #1;
    -> chk_ev;
    #3;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] i, input logic [7:0] d);
    @(negedge clk);
    idx = i; wdata = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] i, input logic [7:0] exp, input string req);
    idx = i;
    expect_v(0, exp, req);
  endtask

  task automatic evt(input logic [7:0] e);
    @(negedge clk);
    rst_evt = e;
    step();
    rst_evt = 8'h00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    latch_open = 1'b1;
    rd(8'h04, 8'h20, "R1");
    rd(8'h05, 8'h04, "R1");
    expect_v(1, 0, "R1");
    expect_v(2, 0, "R1");
    nmi_req = 1'b1;
    expect_v(4, 0, "R1");
    nmi_req = 1'b0;
    soft_rst = 1'b1;
    expect_v(3, 1, "R5");
    soft_rst = 1'b0;
    expect_v(3, 0, "R5");
    latch_open = 1'b0;

    wr(8'h04, 8'h5A);
    rd(8'h04, 8'h5A, "R2");

    evt(8'h01);
    rd(8'h04, 8'h01, "R3");
    evt(8'h81);
    rd(8'h04, 8'h81, "R3");
    @(negedge clk);
    idx = 8'h04; wdata = 8'hFF; wr_en = 1'b1; rst_evt = 8'h08;
    step();
    wr_en = 1'b0; rst_evt = 8'h00;
    rd(8'h04, 8'h08, "R3");

    wr(8'h05, 8'hFF);
    rd(8'h05, 8'h55, "R4");
    wr(8'h05, 8'h00);
    rd(8'h05, 8'h00, "R4");
    soft_rst = 1'b1;
    expect_v(3, 0, "R5");
    soft_rst = 1'b0;

    wr(8'h05, 8'h10);
    latch_open = 1'b1;
    expect_v(2, 1, "R6");
    latch_open = 1'b0;
    expect_v(2, 0, "R6");

    wr(8'h05, 8'h01);
    nmi_req = 1'b1;
    expect_v(4, 1, "R9");
    wr(8'h05, 8'h00);
    expect_v(4, 0, "R9");
    nmi_req = 1'b0;

    wr(8'h05, 8'h40);
    enum_n = 1'b0;
    expect_v(1, 0, "R7");
    step();
    expect_v(1, 1, "R7");
    wr(8'h05, 8'hC0);
    expect_v(1, 0, "R8");
    step();
    expect_v(1, 0, "R8");
    rd(8'h05, 8'h40, "R8");
    enum_n = 1'b1;
    step();
    enum_n = 1'b0;
    step();
    expect_v(1, 1, "R7");
    wr(8'h05, 8'h00);
    expect_v(1, 0, "R8");

    enum_n = 1'b1;
    step();
    enum_n = 1'b0;
    step();
    expect_v(1, 0, "R7");
    wr(8'h05, 8'h40);
    expect_v(1, 0, "R7");
    enum_n = 1'b1;

    wr(8'h06, 8'hFF);
    rd(8'h06, 8'h00, "R10");
    rd(8'h00, 8'h00, "R10");
    rd(8'h04, 8'h08, "R10");
    rd(8'h05, 8'h40, "R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule